// File: doc/BRIEF.md
# Context-Tagged Translation Cache with Invalidation

This block holds recently used address translations for a processor core. It has two parts. The first is a fully associative page cache of 16 entries. Each entry maps a 4 KB page, or a 2 MB page, to a physical frame. The second is a smaller fully associative directory cache. Each of its entries maps a 2 MB-aligned region to the base of a lower-level table. Every entry carries a 12-bit context identifier. Page-cache entries also carry a global flag, which lets them match under any context.

A lookup port takes a linear address and the current context. One cycle later it reports the page-cache hit and frame, and the directory-cache hit and table base. A fill port installs entries, using round-robin slot selection. An invalidation port accepts one command per cycle. Each command carries an opcode, a type, a context, a linear address, a register value and the context-enable mode bit. The decoder turns the command into a selection rule, and every matching entry in both caches is cleared at the next clock edge. Page-table walking, faults, permission checks and replacement tuning are handled elsewhere.

Top module: `ctx_tlb`

## Requirements
- R1: After a synchronous reset, no entry in either cache is valid, all outputs are 0, and the remembered paging state is "enabled".
- R2: A lookup presented in cycle t is reported after the edge that ends cycle t. The page cache hits when an entry is valid, its page number matches and either its context equals the lookup context or the entry is global. A 4 KB entry compares address bits 47:12. A 2 MB entry compares bits 47:21, and its frame is its stored frame bits 39:9 joined with lookup address bits 20:12. The directory cache hits on a valid entry with equal bits 47:21 and equal context. A miss reports a frame of 0.
- R3: Fills write the slot under a round-robin pointer that starts at 0 after reset. The page cache has 16 slots and the directory cache has 8. A fill evicts the previous occupant of its slot.
- R4: Opcode 0 (single-page) clears page entries whose page covers the command address and whose context equals the command context. It also clears global entries covering that address under any context, and every directory entry of the command context whatever its address.
- R5: When several page entries hold the same 2 MB page, a single-page command at any address inside that page clears all of them, subject to the context rule of R4.
- R6: Opcode 1 with type 0 clears non-global page entries that have the command context and cover the command address. It also clears the directory entries of that context.
- R7: Opcode 1 with type 1 clears all non-global page entries of the command context, and the directory entries of that context.
- R8: Opcode 1 with type 2 clears every entry in both caches, globals included.
- R9: Opcode 1 with type 3 clears all non-global page entries of every context, and every directory entry.
- R10: Opcode 2 (mode write) takes the paging-enable bit from value bit 31 and remembers it. Both caches are emptied, globals included, only when the remembered state was enabled and bit 31 is 0.
- R11: Opcode 3 (table-base write) with the context-enable input at 0 clears the non-global page entries and the directory entries whose context is 0. The command context field is ignored.
- R12: Opcode 3 with context-enable at 1 and value bit 63 at 0 clears the non-global page entries and the directory entries of the context in value bits 11:0, and leaves other contexts intact. With bit 63 at 1 it clears nothing.
- R13: Opcode 1 with a type above 3 changes no entry. In that case inv_err is 1 for exactly the cycle after the command, and it is 0 after every other command.
- R14: An invalidation takes effect at the edge that ends its cycle. A lookup in the same cycle reports the state before the invalidation, and a lookup in the following cycle reports the state after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_la | input | 48 | Lookup linear address |
| lk_ctx | input | 12 | Lookup current context |
| lk_hit | output | 1 | Page-cache hit, registered |
| lk_frame | output | 40 | Translated frame number, registered |
| dir_hit | output | 1 | Directory-cache hit, registered |
| dir_base | output | 40 | Directory-cache table base, registered |
| fill_tlb | input | 1 | Install a page-cache entry |
| fill_dir | input | 1 | Install a directory-cache entry |
| fill_la | input | 48 | Fill linear address |
| fill_ctx | input | 12 | Fill context |
| fill_glb | input | 1 | Fill as global (page cache only) |
| fill_large | input | 1 | Fill as 2 MB page (page cache only) |
| fill_frame | input | 40 | Frame number or table base to store |
| inv_vld | input | 1 | Invalidation command valid |
| inv_op | input | 2 | Command opcode (0 page, 1 context, 2 mode write, 3 base write) |
| inv_type | input | 3 | Context-command type |
| inv_ctx | input | 12 | Command context |
| inv_la | input | 48 | Command linear address |
| inv_val | input | 64 | Register value written by opcodes 2 and 3 |
| ctx_ids_on | input | 1 | Context identifiers enabled |
| inv_err | output | 1 | Rejected context-command type, registered |

## Verification
The assertions check four things on every cycle. A valid bit only appears through a fill. A lookup hit needs at least one valid entry in the cycle before. The full-flush type empties both caches. A rejected type, or a table-base write with bit 63 set, leaves every valid bit as it was and sets the error flag only when required. The selection rules need known stored contents to be observed, so only the bench scenarios can show them. These cover which contexts, pages and global entries survive each opcode and type, the clearing of multi-entry 2 MB pages, the edge-triggered memory of the paging state, and the round-robin eviction order. The sweeps refill a fixed mixed pattern before every command and probe every entry afterwards.

// File: rtl/ctx_tlb_pkg.sv
package ctx_tlb_pkg;

  localparam int VAL_W    = 64;
  localparam int TYPE_W   = 3;
  localparam int PG_BIT   = 31;
  localparam int KEEP_BIT = 63;
  localparam logic [TYPE_W-1:0] TYPE_MAX = 3'd3;

  typedef enum logic [1:0] {
    INV_PAGE = 2'd0,
    INV_CTX  = 2'd1,
    INV_MODE = 2'd2,
    INV_BASE = 2'd3
  } inv_op_e;

  // Selection rule handed from the decoder to both arrays
  typedef struct packed {
    logic tlb_clr;
    logic tlb_by_page;
    logic tlb_by_ctx;
    logic tlb_glb_any;
    logic tlb_keep_glb;
    logic dir_clr;
    logic dir_by_ctx;
  } inv_sel_t;

endpackage

// File: rtl/ctx_tlb_inv_dec.sv
module ctx_tlb_inv_dec
  import ctx_tlb_pkg::*;
#(
  parameter int CTX_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inv_vld,
  input  logic [1:0]        inv_op,
  input  logic [TYPE_W-1:0] inv_type,
  input  logic [CTX_W-1:0]  inv_ctx,
  input  logic [VAL_W-1:0]  inv_val,
  input  logic              ctx_ids_on,
  output inv_sel_t          sel,
  output logic [CTX_W-1:0]  sel_ctx,
  output logic              err_q
);

  logic    pg_on_q;
  logic    bad_type;
  inv_op_e op;
  logic    unused_val;

  assign op         = inv_op_e'(inv_op);
  assign bad_type   = inv_vld && (op == INV_CTX) && (inv_type > TYPE_MAX);
  assign unused_val = ^inv_val;

  always_comb begin
    sel     = '0;
    sel_ctx = inv_ctx;
    if (inv_vld) begin
      case (op)
        INV_PAGE: begin
          sel.tlb_clr     = 1'b1;
          sel.tlb_by_page = 1'b1;
          sel.tlb_by_ctx  = 1'b1;
          sel.tlb_glb_any = 1'b1;
          sel.dir_clr     = 1'b1;
          sel.dir_by_ctx  = 1'b1;
        end
        INV_CTX: begin
          case (inv_type)
            3'd0: begin
              sel.tlb_clr      = 1'b1;
              sel.tlb_by_page  = 1'b1;
              sel.tlb_by_ctx   = 1'b1;
              sel.tlb_keep_glb = 1'b1;
              sel.dir_clr      = 1'b1;
              sel.dir_by_ctx   = 1'b1;
            end
            3'd1: begin
              sel.tlb_clr      = 1'b1;
              sel.tlb_by_ctx   = 1'b1;
              sel.tlb_keep_glb = 1'b1;
              sel.dir_clr      = 1'b1;
              sel.dir_by_ctx   = 1'b1;
            end
            3'd2: begin
              sel.tlb_clr = 1'b1;
              sel.dir_clr = 1'b1;
            end
            3'd3: begin
              sel.tlb_clr      = 1'b1;
              sel.tlb_keep_glb = 1'b1;
              sel.dir_clr      = 1'b1;
            end
            default: sel = '0;
          endcase
        end
        INV_MODE: begin
          if (pg_on_q && !inv_val[PG_BIT]) begin
            sel.tlb_clr = 1'b1;
            sel.dir_clr = 1'b1;
          end
        end
        INV_BASE: begin
          if (!ctx_ids_on || !inv_val[KEEP_BIT]) begin
            sel_ctx          = ctx_ids_on ? inv_val[CTX_W-1:0] : '0;
            sel.tlb_clr      = 1'b1;
            sel.tlb_by_ctx   = 1'b1;
            sel.tlb_keep_glb = 1'b1;
            sel.dir_clr      = 1'b1;
            sel.dir_by_ctx   = 1'b1;
          end
        end
        default: sel = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pg_on_q <= 1'b1;
      err_q   <= 1'b0;
    end else begin
      err_q <= bad_type;
      if (inv_vld && op == INV_MODE) pg_on_q <= inv_val[PG_BIT];
    end
  end

endmodule

// File: rtl/ctx_tlb_page_arr.sv
module ctx_tlb_page_arr
  import ctx_tlb_pkg::*;
#(
  parameter int N       = 16,
  parameter int CTX_W   = 12,
  parameter int VPN_W   = 36,
  parameter int LG_BITS = 9,
  parameter int PFN_W   = 40
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fill,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [CTX_W-1:0] fill_ctx,
  input  logic             fill_glb,
  input  logic             fill_lg,
  input  logic [PFN_W-1:0] fill_pfn,
  input  inv_sel_t         sel,
  input  logic [CTX_W-1:0] inv_ctx,
  input  logic [VPN_W-1:0] inv_vpn,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [CTX_W-1:0] lk_ctx,
  output logic             hit_q,
  output logic [PFN_W-1:0] frame_q,
  output logic [N-1:0]     vld_o
);

  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  logic [N-1:0]     vld_q, glb_q, lg_q;
  logic [CTX_W-1:0] ctx_q [N];
  logic [VPN_W-1:0] vpn_q [N];
  logic [PFN_W-1:0] frm_q [N];
  logic [IDX_W-1:0] ptr_q;

  logic [N-1:0]     hit_vec, clr_vec, fill_oh;
  logic [PFN_W-1:0] frame_vec [N];
  logic             hit_n;
  logic [PFN_W-1:0] frame_n;

  assign fill_oh = fill ? ({{(N-1){1'b0}}, 1'b1} << ptr_q) : '0;
  assign vld_o   = vld_q;

  for (genvar i = 0; i < N; i++) begin : g_ent
    logic pm_lk, pm_inv, ctx_ok;
    // 2 MB entries ignore the low page-number bits on both compares
    assign pm_lk  = lg_q[i] ? (vpn_q[i][VPN_W-1:LG_BITS] == lk_vpn[VPN_W-1:LG_BITS])
                            : (vpn_q[i] == lk_vpn);
    assign pm_inv = lg_q[i] ? (vpn_q[i][VPN_W-1:LG_BITS] == inv_vpn[VPN_W-1:LG_BITS])
                            : (vpn_q[i] == inv_vpn);
    assign ctx_ok = !sel.tlb_by_ctx || (ctx_q[i] == inv_ctx) ||
                    (glb_q[i] && sel.tlb_glb_any);
    assign clr_vec[i] = sel.tlb_clr && vld_q[i] && (!sel.tlb_by_page || pm_inv) &&
                        ctx_ok && !(sel.tlb_keep_glb && glb_q[i]);
    assign hit_vec[i] = vld_q[i] && pm_lk && ((ctx_q[i] == lk_ctx) || glb_q[i]);
    assign frame_vec[i] = lg_q[i] ? {frm_q[i][PFN_W-1:LG_BITS], lk_vpn[LG_BITS-1:0]}
                                  : frm_q[i];
  end

  // Lowest-index hit wins
  always_comb begin
    hit_n   = 1'b0;
    frame_n = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        hit_n   = 1'b1;
        frame_n = frame_vec[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q   <= '0;
      ptr_q   <= '0;
      hit_q   <= 1'b0;
      frame_q <= '0;
    end else begin
      vld_q   <= (vld_q & ~clr_vec) | fill_oh;
      hit_q   <= hit_n;
      frame_q <= frame_n;
      if (fill) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  // Payload storage without reset
  always_ff @(posedge clk) begin
    if (fill) begin
      ctx_q[ptr_q] <= fill_ctx;
      vpn_q[ptr_q] <= fill_vpn;
      frm_q[ptr_q] <= fill_pfn;
      glb_q[ptr_q] <= fill_glb;
      lg_q[ptr_q]  <= fill_lg;
    end
  end

endmodule

// File: rtl/ctx_tlb_dir_arr.sv
module ctx_tlb_dir_arr
  import ctx_tlb_pkg::*;
#(
  parameter int N      = 8,
  parameter int CTX_W  = 12,
  parameter int TAG_W  = 27,
  parameter int BASE_W = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fill,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [CTX_W-1:0]  fill_ctx,
  input  logic [BASE_W-1:0] fill_base,
  input  inv_sel_t          sel,
  input  logic [CTX_W-1:0]  inv_ctx,
  input  logic [TAG_W-1:0]  lk_tag,
  input  logic [CTX_W-1:0]  lk_ctx,
  output logic              hit_q,
  output logic [BASE_W-1:0] base_q,
  output logic [N-1:0]      vld_o
);

  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  logic [N-1:0]      vld_q;
  logic [CTX_W-1:0]  ctx_q  [N];
  logic [TAG_W-1:0]  tag_q  [N];
  logic [BASE_W-1:0] bas_q  [N];
  logic [IDX_W-1:0]  ptr_q;

  logic [N-1:0]      hit_vec, clr_vec, fill_oh;
  logic              hit_n;
  logic [BASE_W-1:0] base_n;

  assign fill_oh = fill ? ({{(N-1){1'b0}}, 1'b1} << ptr_q) : '0;
  assign vld_o   = vld_q;

  for (genvar i = 0; i < N; i++) begin : g_ent
    assign clr_vec[i] = sel.dir_clr && vld_q[i] &&
                        (!sel.dir_by_ctx || (ctx_q[i] == inv_ctx));
    assign hit_vec[i] = vld_q[i] && (tag_q[i] == lk_tag) && (ctx_q[i] == lk_ctx);
  end

  always_comb begin
    hit_n  = 1'b0;
    base_n = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        hit_n  = 1'b1;
        base_n = bas_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= '0;
      ptr_q  <= '0;
      hit_q  <= 1'b0;
      base_q <= '0;
    end else begin
      vld_q  <= (vld_q & ~clr_vec) | fill_oh;
      hit_q  <= hit_n;
      base_q <= base_n;
      if (fill) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill) begin
      ctx_q[ptr_q] <= fill_ctx;
      tag_q[ptr_q] <= fill_tag;
      bas_q[ptr_q] <= fill_base;
    end
  end

endmodule

// File: rtl/ctx_tlb.sv
module ctx_tlb
  import ctx_tlb_pkg::*;
#(
  parameter int LA_W     = 48,
  parameter int CTX_W    = 12,
  parameter int PFN_W    = 40,
  parameter int TLB_N    = 16,
  parameter int DIR_N    = 8,
  parameter int PG_SHIFT = 12,
  parameter int LG_SHIFT = 21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LA_W-1:0]   lk_la,
  input  logic [CTX_W-1:0]  lk_ctx,
  output logic              lk_hit,
  output logic [PFN_W-1:0]  lk_frame,
  output logic              dir_hit,
  output logic [PFN_W-1:0]  dir_base,
  input  logic              fill_tlb,
  input  logic              fill_dir,
  input  logic [LA_W-1:0]   fill_la,
  input  logic [CTX_W-1:0]  fill_ctx,
  input  logic              fill_glb,
  input  logic              fill_large,
  input  logic [PFN_W-1:0]  fill_frame,
  input  logic              inv_vld,
  input  logic [1:0]        inv_op,
  input  logic [TYPE_W-1:0] inv_type,
  input  logic [CTX_W-1:0]  inv_ctx,
  input  logic [LA_W-1:0]   inv_la,
  input  logic [VAL_W-1:0]  inv_val,
  input  logic              ctx_ids_on,
  output logic              inv_err
);

  localparam int VPN_W   = LA_W - PG_SHIFT;
  localparam int TAG_W   = LA_W - LG_SHIFT;
  localparam int LG_BITS = LG_SHIFT - PG_SHIFT;

  inv_sel_t         sel;
  logic [CTX_W-1:0] sel_ctx;
  logic [TLB_N-1:0] tlb_vld;
  logic [DIR_N-1:0] dir_vld;
  logic             unused_low;

  assign unused_low = ^{lk_la[PG_SHIFT-1:0], fill_la[PG_SHIFT-1:0], inv_la[PG_SHIFT-1:0]};

  ctx_tlb_inv_dec #(.CTX_W(CTX_W)) u_dec (
    .clk        (clk),
    .rst        (rst),
    .inv_vld    (inv_vld),
    .inv_op     (inv_op),
    .inv_type   (inv_type),
    .inv_ctx    (inv_ctx),
    .inv_val    (inv_val),
    .ctx_ids_on (ctx_ids_on),
    .sel        (sel),
    .sel_ctx    (sel_ctx),
    .err_q      (inv_err)
  );

  ctx_tlb_page_arr #(
    .N(TLB_N), .CTX_W(CTX_W), .VPN_W(VPN_W), .LG_BITS(LG_BITS), .PFN_W(PFN_W)
  ) u_page (
    .clk      (clk),
    .rst      (rst),
    .fill     (fill_tlb),
    .fill_vpn (fill_la[LA_W-1:PG_SHIFT]),
    .fill_ctx (fill_ctx),
    .fill_glb (fill_glb),
    .fill_lg  (fill_large),
    .fill_pfn (fill_frame),
    .sel      (sel),
    .inv_ctx  (sel_ctx),
    .inv_vpn  (inv_la[LA_W-1:PG_SHIFT]),
    .lk_vpn   (lk_la[LA_W-1:PG_SHIFT]),
    .lk_ctx   (lk_ctx),
    .hit_q    (lk_hit),
    .frame_q  (lk_frame),
    .vld_o    (tlb_vld)
  );

  ctx_tlb_dir_arr #(
    .N(DIR_N), .CTX_W(CTX_W), .TAG_W(TAG_W), .BASE_W(PFN_W)
  ) u_dir (
    .clk       (clk),
    .rst       (rst),
    .fill      (fill_dir),
    .fill_tag  (fill_la[LA_W-1:LG_SHIFT]),
    .fill_ctx  (fill_ctx),
    .fill_base (fill_frame),
    .sel       (sel),
    .inv_ctx   (sel_ctx),
    .lk_tag    (lk_la[LA_W-1:LG_SHIFT]),
    .lk_ctx    (lk_ctx),
    .hit_q     (dir_hit),
    .base_q    (dir_base),
    .vld_o     (dir_vld)
  );

endmodule

// File: rtl/ctx_tlb_chk.sv
module ctx_tlb_chk #(
  parameter int N_TLB = 16,
  parameter int N_DIR = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             inv_vld,
  input logic [1:0]       inv_op,
  input logic [2:0]       inv_type,
  input logic             keep_bit,
  input logic             ctx_ids_on,
  input logic             fill_tlb,
  input logic             fill_dir,
  input logic [N_TLB-1:0] tlb_vld,
  input logic [N_DIR-1:0] dir_vld,
  input logic             lk_hit,
  input logic             inv_err
);

  logic bad_cmd, flush_cmd, skip_cmd, no_fill;
  assign bad_cmd   = inv_vld && inv_op == 2'd1 && inv_type > 3'd3;
  assign flush_cmd = inv_vld && inv_op == 2'd1 && inv_type == 3'd2;
  assign skip_cmd  = inv_vld && inv_op == 2'd3 && ctx_ids_on && keep_bit;
  assign no_fill   = !fill_tlb && !fill_dir;

  p_err_set_r13: assert property (@(posedge clk) disable iff (rst)
    bad_cmd |=> inv_err);

  p_err_cause_r13: assert property (@(posedge clk) disable iff (rst)
    inv_err |-> $past(bad_cmd));

  p_bad_keep_r13: assert property (@(posedge clk) disable iff (rst)
    (bad_cmd && no_fill) |=> ($stable(tlb_vld) && $stable(dir_vld)));

  p_flush_all_r8: assert property (@(posedge clk) disable iff (rst)
    (flush_cmd && no_fill) |=> (tlb_vld == '0 && dir_vld == '0));

  p_base_skip_r12: assert property (@(posedge clk) disable iff (rst)
    (skip_cmd && no_fill) |=> ($stable(tlb_vld) && $stable(dir_vld)));

  p_tlb_new_r3: assert property (@(posedge clk) disable iff (rst)
    !fill_tlb |=> ((tlb_vld & ~$past(tlb_vld)) == '0));

  p_dir_new_r3: assert property (@(posedge clk) disable iff (rst)
    !fill_dir |=> ((dir_vld & ~$past(dir_vld)) == '0));

  p_hit_src_r2: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> ($past(tlb_vld) != '0));

endmodule

bind ctx_tlb ctx_tlb_chk #(.N_TLB(TLB_N), .N_DIR(DIR_N)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .inv_vld    (inv_vld),
  .inv_op     (inv_op),
  .inv_type   (inv_type),
  .keep_bit   (inv_val[63]),
  .ctx_ids_on (ctx_ids_on),
  .fill_tlb   (fill_tlb),
  .fill_dir   (fill_dir),
  .tlb_vld    (tlb_vld),
  .dir_vld    (dir_vld),
  .lk_hit     (lk_hit),
  .inv_err    (inv_err)
);

// File: tb/sim_ctx_tlb.sv
module sim_ctx_tlb;

  logic        clk = 1'b0;
  logic        rst;
  logic [47:0] lk_la;
  logic [11:0] lk_ctx;
  logic        lk_hit;
  logic [39:0] lk_frame;
  logic        dir_hit;
  logic [39:0] dir_base;
  logic        fill_tlb, fill_dir;
  logic [47:0] fill_la;
  logic [11:0] fill_ctx;
  logic        fill_glb, fill_large;
  logic [39:0] fill_frame;
  logic        inv_vld;
  logic [1:0]  inv_op;
  logic [2:0]  inv_type;
  logic [11:0] inv_ctx;
  logic [47:0] inv_la;
  logic [63:0] inv_val;
  logic        ctx_ids_on;
  logic        inv_err;

  int vecs = 0;
  int bad  = 0;
  bit done = 0;
  bit exp_pg;
  logic [15:0] t_alive;
  logic [7:0]  d_alive;

  always #4 clk = ~clk;

  ctx_tlb u0 (.*);

  // Fixed fill pattern
  function automatic logic [47:0] t_la(int i);
    if (i >= 14) return 48'h0000_4020_0000 + 48'(i - 14) * 48'h3000;
    return 48'h0A00_0000_0000 + (48'(i + 1) << 12);
  endfunction
  function automatic logic [11:0] t_ctx(int i); return 12'(i % 4); endfunction
  function automatic bit t_glb(int i); return (i % 3) == 0; endfunction
  function automatic bit t_lg(int i); return i >= 14; endfunction
  function automatic logic [39:0] t_pfn(int i);
    return (i >= 14) ? 40'h00_0ABC_0000 : 40'h100 + 40'(i);
  endfunction
  function automatic logic [47:0] d_la(int j);
    return 48'h0000_8000_0000 + (48'(j) << 21);
  endfunction
  function automatic logic [11:0] d_ctx(int j); return 12'(j % 4); endfunction
  function automatic logic [39:0] d_base(int j); return 40'h5500 + 40'(j); endfunction

  function automatic bit t_pm(int k, logic [47:0] la);
    logic [47:0] e;
    e = t_la(k);
    return t_lg(k) ? (la[47:21] == e[47:21]) : (la[47:12] == e[47:12]);
  endfunction

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    lk_la = '0; lk_ctx = '0;
    fill_tlb = 0; fill_dir = 0; fill_la = '0; fill_ctx = '0;
    fill_glb = 0; fill_large = 0; fill_frame = '0;
    inv_vld = 0; inv_op = '0; inv_type = '0; inv_ctx = '0;
    inv_la = '0; inv_val = '0; ctx_ids_on = 0;
  endtask

  task automatic refill();
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      fill_tlb = 1; fill_la = t_la(i); fill_ctx = t_ctx(i);
      fill_glb = t_glb(i); fill_large = t_lg(i); fill_frame = t_pfn(i);
    end
    @(negedge clk);
    fill_tlb = 0; fill_glb = 0; fill_large = 0;
    for (int j = 0; j < 8; j++) begin
      fill_dir = 1; fill_la = d_la(j); fill_ctx = d_ctx(j); fill_frame = d_base(j);
      @(negedge clk);
    end
    fill_dir = 0;
    t_alive = '1;
    d_alive = '1;
  endtask

  task automatic probe(string tag, logic [47:0] la, logic [11:0] ctx);
    bit eh, edh;
    logic [39:0] ef, eb, p;
    logic [47:0] dl;
    @(negedge clk);
    lk_la = la; lk_ctx = ctx;
    @(posedge clk);
    @(negedge clk);
    eh = 0; ef = '0; edh = 0; eb = '0;
    for (int k = 0; k < 16; k++) begin
      if (t_alive[k] && t_pm(k, la) && (t_ctx(k) == ctx || t_glb(k))) begin
        eh = 1;
        p  = t_pfn(k);
        ef = t_lg(k) ? {p[39:9], la[20:12]} : p;
      end
    end
    for (int j = 0; j < 8; j++) begin
      dl = d_la(j);
      if (d_alive[j] && dl[47:21] == la[47:21] && d_ctx(j) == ctx) begin
        edh = 1; eb = d_base(j);
      end
    end
    chk(tag, "page hit", 64'(lk_hit), 64'(eh));
    chk(tag, "frame", 64'(lk_frame), 64'(ef));
    chk(tag, "dir hit", 64'(dir_hit), 64'(edh));
    chk(tag, "dir base", 64'(dir_base), 64'(eb));
  endtask

  task automatic probe_all(string tag);
    for (int i = 0; i < 16; i++) probe(tag, t_la(i), t_ctx(i));
    for (int j = 0; j < 8; j++) probe(tag, d_la(j), d_ctx(j));
  endtask

  // Refill, apply one command, compare survivors with the rule model
  task automatic scen(string tag, logic [1:0] op, logic [2:0] ty, logic [11:0] ctx,
                      logic [47:0] la, logic [63:0] val, bit on);
    bit trans, c, g;
    logic [11:0] sctx, kc;
    refill();
    trans = exp_pg && !val[31];
    sctx  = on ? val[11:0] : 12'h0;
    for (int k = 0; k < 16; k++) begin
      kc = t_ctx(k); g = t_glb(k);
      case (op)
        2'd0: c = t_pm(k, la) && (kc == ctx || g);
        2'd1: case (ty)
                3'd0: c = !g && kc == ctx && t_pm(k, la);
                3'd1: c = !g && kc == ctx;
                3'd2: c = 1;
                3'd3: c = !g;
                default: c = 0;
              endcase
        2'd2: c = trans;
        default: c = (on && val[63]) ? 0 : (!g && kc == sctx);
      endcase
      if (c) t_alive[k] = 0;
    end
    for (int j = 0; j < 8; j++) begin
      kc = d_ctx(j);
      case (op)
        2'd0: c = kc == ctx;
        2'd1: c = (ty <= 3'd1) ? (kc == ctx) : (ty <= 3'd3);
        2'd2: c = trans;
        default: c = (on && val[63]) ? 0 : (kc == sctx);
      endcase
      if (c) d_alive[j] = 0;
    end
    if (op == 2'd2) exp_pg = val[31];
    @(negedge clk);
    inv_vld = 1; inv_op = op; inv_type = ty; inv_ctx = ctx;
    inv_la = la; inv_val = val; ctx_ids_on = on;
    @(posedge clk);
    @(negedge clk);
    inv_vld = 0;
    chk(tag, "inv_err", 64'(inv_err), 64'(op == 2'd1 && ty > 3'd3));
    probe_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    int ei [4] = '{0, 5, 10, 14};
    logic [31:0] mv [5] = '{32'h0, 32'h0, 32'h8000_0000, 32'h8000_0000, 32'h0};
    idle();
    exp_pg = 1;
    t_alive = '0; d_alive = '0;
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: outputs clear after reset, nothing cached
    chk("R1", "lk_hit", 64'(lk_hit), 64'h0);
    chk("R1", "dir_hit", 64'(dir_hit), 64'h0);
    chk("R1", "inv_err", 64'(inv_err), 64'h0);
    probe("R1", t_la(0), t_ctx(0));
    probe("R1", d_la(0), d_ctx(0));

    // R2: hit rule, wrong-context probes, 2 MB frame composition
    refill();
    probe_all("R2");
    for (int i = 0; i < 16; i++) probe("R2", t_la(i), 12'((i + 1) % 4));
    probe("R2", t_la(14) + 48'h5_000, 12'h2);
    probe("R2", t_la(15) + 48'h1F_F000, 12'h7);

    // R3: next fill goes to slot 0 in both caches
    @(negedge clk);
    fill_tlb = 1; fill_la = 48'h0B00_0000_0000; fill_ctx = 12'h0;
    fill_glb = 0; fill_large = 0; fill_frame = 40'h777;
    @(negedge clk);
    fill_tlb = 0;
    fill_dir = 1; fill_la = 48'h0000_9000_0000; fill_ctx = 12'h1; fill_frame = 40'h999;
    @(negedge clk);
    fill_dir = 0;
    t_alive[0] = 0; d_alive[0] = 0;
    probe("R3", t_la(0), t_ctx(0));
    probe("R3", t_la(1), t_ctx(1));
    probe("R3", d_la(0), d_ctx(0));
    @(negedge clk);
    lk_la = 48'h0B00_0000_0000; lk_ctx = 12'h0;
    @(posedge clk); @(negedge clk);
    chk("R3", "new page hit", 64'(lk_hit), 64'h1);
    chk("R3", "new frame", 64'(lk_frame), 64'h777);
    lk_la = 48'h0000_9000_0000; lk_ctx = 12'h1;
    @(posedge clk); @(negedge clk);
    chk("R3", "new dir hit", 64'(dir_hit), 64'h1);
    chk("R3", "new dir base", 64'(dir_base), 64'h999);

    // R4 / R5: single-page commands at every pattern address and context
    for (int e = 0; e < 16; e++)
      for (int c = 0; c < 4; c++)
        scen((e >= 14) ? "R5" : "R4", 2'd0, 3'd0, 12'(c), t_la(e) + 48'h123, 64'h0, 0);

    // R6..R9, R13: every context-command type
    for (int ty = 0; ty < 8; ty++)
      for (int c = 0; c < 4; c++)
        for (int x = 0; x < 4; x++)
          scen(ty == 0 ? "R6" : ty == 1 ? "R7" : ty == 2 ? "R8" : ty == 3 ? "R9" : "R13",
               2'd1, 3'(ty), 12'(c), t_la(ei[x]) + 48'h40, 64'h0, 0);

    // R10: only an enabled-to-disabled change flushes
    for (int m = 0; m < 5; m++)
      scen("R10", 2'd2, 3'd0, 12'h1, 48'h0, {32'h1234_0000, mv[m] | 32'h0000_0011}, 0);

    // R11 / R12: table-base writes, command context deliberately wrong
    for (int on = 0; on < 2; on++)
      for (int h = 0; h < 2; h++)
        for (int c = 0; c < 4; c++)
          scen(on == 0 ? "R11" : "R12", 2'd3, 3'd0, 12'(3 - c), 48'h0,
               {1'(h), 51'h0_0400_0000_0300, 12'(c)}, 1'(on));

    // R14: same-cycle lookup sees old state, next cycle sees new
    refill();
    @(negedge clk);
    inv_vld = 1; inv_op = 2'd1; inv_type = 3'd2;
    lk_la = t_la(1); lk_ctx = t_ctx(1);
    @(posedge clk); @(negedge clk);
    inv_vld = 0;
    chk("R14", "same-cycle hit", 64'(lk_hit), 64'h1);
    @(posedge clk); @(negedge clk);
    chk("R14", "next-cycle hit", 64'(lk_hit), 64'h0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

endmodule